// File: doc/BRIEF.md
# Six-Button Gamepad Multiplex Responder

This block plays the controller side of one console gamepad port. The host drives a select line: bit 6 of the port data register, called TH here. The host reads back an 8-bit value whose low six bits show one group of buttons or another, depending on TH. When the six-button option is on, the block counts host writes that raise TH from 0 to 1. Particular counts, called phases, then expose the four extra buttons (mode, X, Y, Z) and an all-ones identification nibble. A timeout, advanced by a host-supplied tick such as a once-per-scanline strobe, returns the sequence to phase 0.

Buttons arrive active-high as a 12-bit vector. From bit 11 down to bit 0 it holds mode, X, Y, Z, start, A, C, B, right, left, down, up. The block presents every button inverted, so a pressed button reads 0. The block holds the port data register and loads it on a host write strobe. The direction (control) register is a plain input, where a 1 marks an output bit. A system with two ports uses two independent instances.

Top module: `gpad_mux_port`

## Requirements
- R1: While reset is asserted, and right after it, the phase and the timeout count are 0 and the data register is 0x00. With all direction bits as inputs, the read value is then {0, 0, ~start, ~A, 0, 0, ~down, ~up}.
- R2: When the base mapping applies and TH = 1, read bits 5..0 are ~{C, B, right, left, down, up}.
- R3: When the base mapping applies and TH = 0, read bits 5..4 are ~{start, A}, bits 3..2 are 0 and bits 1..0 are ~{down, up}.
- R4: With six-button mode on, phase 2 and TH = 0, read bits 5..4 are ~{start, A} and bits 3..0 are 0.
- R5: With six-button mode on, phase 3 and TH = 1, read bits 5..4 are ~{C, B} and bits 3..0 are ~{mode, X, Y, Z}.
- R6: With six-button mode on, phase 3 and TH = 0, read bits 5..4 are ~{start, A} and bits 3..0 are 1111.
- R7: The 3-bit phase rises by one on a host write only when the write moves TH from 0 to 1 and six-button mode is on. It wraps from 7 to 0. Phases other than 2 and 3 use the base mapping.
- R8: With six-button mode off, writes never change the phase, and the base mapping applies in every phase.
- R9: Every host write to the data register restarts the timeout count. It does so even when the write and a tick fall in the same cycle.
- R10: After TIMEOUT_TICKS ticks with no data write between them, the phase returns to 0 in the same cycle as the last of those ticks.
- R11: Bit 7, and every bit that the direction register marks as an output, reads back the data register bit. Bit 6 reads 0 when it is an input.
- R12: The read value is combinational from the block's registers and its inputs. A write shows in the read value from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buttons_i | input | 12 | Active-high buttons: mode, X, Y, Z, start, A, C, B, right, left, down, up (bit 11 down to 0) |
| six_en_i | input | 1 | Enables the six-button phase sequence |
| ctrl_dir_i | input | 8 | Direction register, 1 = output bit |
| data_wr_i | input | 1 | Host write strobe for the data register |
| data_wdata_i | input | 8 | Host write data, bit 6 = TH |
| tick_i | input | 1 | Timeout tick, for example once per scanline |
| rd_data_o | output | 8 | Value the host reads from the port |

## Verification
The bench builds the block with TIMEOUT_TICKS = 4. With that value, timeout expiry, and a write that arrives one tick before expiry, take only a few cycles, so both can be exercised many times. It drives enough TH rises to walk the 3-bit phase through its full wrap, which reaches phases 2, 3 and the unused phases 4 to 7. It also mixes direction-register settings with the button patterns, so that output bits can be seen overriding the button groups.

// File: rtl/gpad_mux_pkg.sv
package gpad_mux_pkg;

    localparam int TH_BIT   = 6;
    localparam int BTN_W    = 12;
    localparam int PHASE_W  = 3;

    // button positions in the active-high input vector
    localparam int B_MODE  = 11;
    localparam int B_X     = 10;
    localparam int B_Y     = 9;
    localparam int B_Z     = 8;
    localparam int B_START = 7;
    localparam int B_A     = 6;
    localparam int B_C     = 5;
    localparam int B_B     = 4;
    localparam int B_RIGHT = 3;
    localparam int B_LEFT  = 2;
    localparam int B_DOWN  = 1;
    localparam int B_UP    = 0;

    typedef enum logic [2:0] {
        SEL_BASE_HI,
        SEL_BASE_LO,
        SEL_EXT_CLR,
        SEL_EXT_HI,
        SEL_EXT_ID
    } grp_sel_e;

endpackage

// File: rtl/gpad_data_reg.sv
module gpad_data_reg
    import gpad_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] data_o,
    output logic       th_rise_o
);

    typedef struct packed {
        logic [7:0] data;
    } dreg_t;

    dreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o    = st_q.data;
    assign th_rise_o = wr_i && !st_q.data[TH_BIT] && wdata_i[TH_BIT];

endmodule

// File: rtl/gpad_phase_ctl.sv
module gpad_phase_ctl
    import gpad_mux_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               th_rise_i,
    input  logic               six_en_i,
    input  logic               tick_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [$clog2(TIMEOUT_TICKS)-1:0] tmo_o
);

    localparam int TO_W = $clog2(TIMEOUT_TICKS);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_TICKS - 1);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [TO_W-1:0]    tmo;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.tmo = '0;
            if (th_rise_i && six_en_i) begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end else if (tick_i) begin
            if (st_q.tmo == TO_LAST) begin
                st_d.tmo   = '0;
                st_d.phase = '0;
            end else begin
                st_d.tmo = st_q.tmo + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign tmo_o   = st_q.tmo;

endmodule

// File: rtl/gpad_read_mux.sv
module gpad_read_mux
    import gpad_mux_pkg::*;
(
    input  logic [BTN_W-1:0]   buttons_i,
    input  logic [7:0]         data_i,
    input  logic [7:0]         dir_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               six_en_i,
    output logic [7:0]         rd_o
);

    grp_sel_e         sel;
    logic [BTN_W-1:0] pn;
    logic [5:0]       grp;
    logic [7:0]       pins;
    logic             th;

    assign th = data_i[TH_BIT];
    assign pn = ~buttons_i;

    always_comb begin
        if (six_en_i && phase_i == PHASE_W'(3)) begin
            sel = th ? SEL_EXT_HI : SEL_EXT_ID;
        end else if (six_en_i && phase_i == PHASE_W'(2) && !th) begin
            sel = SEL_EXT_CLR;
        end else begin
            sel = th ? SEL_BASE_HI : SEL_BASE_LO;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_BASE_HI: grp = {pn[B_C], pn[B_B], pn[B_RIGHT], pn[B_LEFT], pn[B_DOWN], pn[B_UP]};
            SEL_BASE_LO: grp = {pn[B_START], pn[B_A], 2'b00, pn[B_DOWN], pn[B_UP]};
            SEL_EXT_CLR: grp = {pn[B_START], pn[B_A], 4'b0000};
            SEL_EXT_HI:  grp = {pn[B_C], pn[B_B], pn[B_MODE], pn[B_X], pn[B_Y], pn[B_Z]};
            SEL_EXT_ID:  grp = {pn[B_START], pn[B_A], 4'b1111};
            default:     grp = '0;
        endcase
    end

    assign pins = {2'b00, grp};

    for (genvar i = 0; i < 8; i++) begin : g_bit
        if (i == 7) begin : g_top
            assign rd_o[i] = data_i[i];
        end else begin : g_pin
            assign rd_o[i] = dir_i[i] ? data_i[i] : pins[i];
        end
    end

endmodule

// File: rtl/gpad_mux_port.sv
module gpad_mux_port
    import gpad_mux_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] buttons_i,
    input  logic        six_en_i,
    input  logic [7:0]  ctrl_dir_i,
    input  logic        data_wr_i,
    input  logic [7:0]  data_wdata_i,
    input  logic        tick_i,
    output logic [7:0]  rd_data_o
);

    localparam int TO_W = $clog2(TIMEOUT_TICKS);

    logic [7:0]         data_q;
    logic               th_rise;
    logic [PHASE_W-1:0] phase_q;
    logic [TO_W-1:0]    tmo_q;

    gpad_data_reg u_dreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (data_wr_i),
        .wdata_i   (data_wdata_i),
        .data_o    (data_q),
        .th_rise_o (th_rise)
    );

    gpad_phase_ctl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (data_wr_i),
        .th_rise_i (th_rise),
        .six_en_i  (six_en_i),
        .tick_i    (tick_i),
        .phase_o   (phase_q),
        .tmo_o     (tmo_q)
    );

    gpad_read_mux u_mux (
        .buttons_i (buttons_i),
        .data_i    (data_q),
        .dir_i     (ctrl_dir_i),
        .phase_i   (phase_q),
        .six_en_i  (six_en_i),
        .rd_o      (rd_data_o)
    );

endmodule

// File: rtl/gpad_mux_chk.sv
module gpad_mux_chk #(
    parameter int TIMEOUT_TICKS = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        six_en_i,
    input logic [7:0]  ctrl_dir_i,
    input logic        data_wr_i,
    input logic [7:0]  data_wdata_i,
    input logic        tick_i,
    input logic [7:0]  rd_data_o,
    input logic [7:0]  data_q,
    input logic [2:0]  phase_q,
    input logic [$clog2(TIMEOUT_TICKS)-1:0] tmo_q
);

    localparam int TO_W = $clog2(TIMEOUT_TICKS);

    // R7
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && six_en_i && !data_q[6] && data_wdata_i[6])
        |=> (phase_q == 3'($past(phase_q) + 3'd1)));

    // R8
    six_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!six_en_i && !tick_i) |=> $stable(phase_q));

    // R9
    wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_i |=> (tmo_q == '0));

    // R10
    tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tmo_q) < TIMEOUT_TICKS));

    // R10
    tmo_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !data_wr_i && tmo_q == TO_W'(TIMEOUT_TICKS - 1))
        |=> (phase_q == 3'd0));

    // R11
    top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[7] == data_q[7]);

    // R6
    id_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (six_en_i && phase_q == 3'd3 && !data_q[6] && ctrl_dir_i[3:0] == 4'h0)
        |-> (rd_data_o[3:0] == 4'hF));

endmodule

bind gpad_mux_port gpad_mux_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .six_en_i     (six_en_i),
    .ctrl_dir_i   (ctrl_dir_i),
    .data_wr_i    (data_wr_i),
    .data_wdata_i (data_wdata_i),
    .tick_i       (tick_i),
    .rd_data_o    (rd_data_o),
    .data_q       (data_q),
    .phase_q      (phase_q),
    .tmo_q        (tmo_q)
);

// File: tb/gpad_mux_port_tb.sv
module gpad_mux_port_tb;

    localparam int TMO = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] buttons = '0;
    logic        six_en = 1'b0;
    logic [7:0]  ctrl = '0;
    logic        data_wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic        tick = 1'b0;
    logic [7:0]  rd;

    int n_checks = 0;
    int n_errors = 0;
    string cur_req = "";

    // behavioural reference state
    int m_data = 0;
    int m_phase = 0;
    int m_tmo = 0;

    always #2 clk = ~clk;

    gpad_mux_port #(.TIMEOUT_TICKS(TMO)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .buttons_i    (buttons),
        .six_en_i     (six_en),
        .ctrl_dir_i   (ctrl),
        .data_wr_i    (data_wr),
        .data_wdata_i (wdata),
        .tick_i       (tick),
        .rd_data_o    (rd)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_phase = 0; m_tmo = 0;
        end else if (data_wr) begin
            if (six_en && ((m_data & 'h40) == 0) && wdata[6])
                m_phase = (m_phase + 1) % 8;
            m_tmo = 0;
            m_data = int'(wdata);
        end else if (tick) begin
            m_tmo = m_tmo + 1;
            if (m_tmo == TMO) begin
                m_tmo = 0;
                m_phase = 0;
            end
        end
    end

    function automatic logic [7:0] expect_rd(output string tag);
        logic [11:0] p;
        logic [5:0]  low;
        logic [7:0]  r;
        logic [7:0]  d;
        bit          th;
        p  = ~buttons;
        d  = 8'(m_data);
        th = d[6];
        if (six_en && m_phase == 2 && !th) begin
            low = {p[7], p[6], 4'b0000}; tag = "R4";
        end else if (six_en && m_phase == 3 && th) begin
            low = {p[5], p[4], p[11], p[10], p[9], p[8]}; tag = "R5";
        end else if (six_en && m_phase == 3) begin
            low = {p[7], p[6], 4'b1111}; tag = "R6";
        end else if (th) begin
            low = p[5:0]; tag = "R2";
        end else begin
            low = {p[7], p[6], 2'b00, p[1], p[0]}; tag = "R3";
        end
        r[7] = d[7];
        r[6] = ctrl[6] ? d[6] : 1'b0;
        for (int i = 0; i < 6; i++) r[i] = ctrl[i] ? d[i] : low[i];
        if (ctrl != 0) tag = "R11";
        if (!rst_n) tag = "R1";
        if (cur_req != "") tag = cur_req;
        return r;
    endfunction

    task automatic cyc();
        string tag;
        logic [7:0] e;
        @(posedge clk);
        #1;
        e = expect_rd(tag);
        n_checks++;
        if (rd !== e) begin
            n_errors++;
            $display("FAIL %s (R12 timing): rd=%02h expected=%02h phase=%0d th=%0d",
                     tag, rd, e, m_phase, (m_data >> 6) & 1);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        data_wr = 1'b1; wdata = d;
        cyc();
        data_wr = 1'b0;
        cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc(); tick = 1'b0;
        end
        cyc();
    endtask

    initial begin
        #100000;
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1: reset state, all buttons released then some pressed
        buttons = 12'h000;
        cyc(); cyc();
        buttons = 12'h0C3;
        cyc();
        rst_n = 1'b1;
        cyc(); cyc();

        // R2, R3: base mapping, several patterns, six-button off
        for (int k = 0; k < 6; k++) begin
            buttons = 12'(12'h5A3 * (k + 1) ^ (k << 7));
            wr(8'h40);
            wr(8'h00);
        end

        // R8: rises with six-button off never move the phase
        cur_req = "R8";
        buttons = 12'hF0F;
        for (int k = 0; k < 3; k++) begin wr(8'h40); wr(8'h00); end
        six_en = 1'b1;
        cyc();
        cur_req = "";

        // R4, R5, R6, R7: walk the phase through a full wrap
        for (int k = 0; k < 9; k++) begin
            buttons = 12'(12'h3C5 + k * 12'h111);
            wr(8'h40);
            wr(8'h00);
        end
        // R7: rewriting TH high while already high does not step
        cur_req = "R7";
        wr(8'h40); wr(8'h40); wr(8'hC0); wr(8'h00);
        cur_req = "";

        // R10: timeout returns the phase to 0 (reach phase 3 first)
        cur_req = "R10";
        ticks(TMO);
        wr(8'h40); wr(8'h00); wr(8'h40); wr(8'h00); wr(8'h40);
        ticks(TMO - 1);
        wr(8'h00);
        ticks(TMO);
        cur_req = "";

        // R9: write one tick before expiry restarts the count
        cur_req = "R9";
        wr(8'h40); wr(8'h00); wr(8'h40); wr(8'h00); wr(8'h40);
        ticks(TMO - 1);
        tick = 1'b1; data_wr = 1'b1; wdata = 8'h00; cyc();
        tick = 1'b0; data_wr = 1'b0; cyc();
        ticks(TMO - 1);
        ticks(1);
        cur_req = "";

        // R11: direction bits and bit 7 show the data register
        buttons = 12'hA5A;
        ctrl = 8'h0F; wr(8'hA5); wr(8'h5A);
        ctrl = 8'h40; wr(8'h40); wr(8'h80);
        ctrl = 8'h30; wr(8'hF0); wr(8'h4F);
        ctrl = 8'h00; wr(8'h80);

        // R8: disabling mid-sequence falls back to the base mapping
        wr(8'h40); wr(8'h00); wr(8'h40); wr(8'h00);
        six_en = 1'b0; cyc(); wr(8'h40); wr(8'h00);
        six_en = 1'b1; cyc(); cyc();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule